// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It receives the whole 32-bit condition register, a 3-bit number that picks one of its eight 4-bit flag groups, and a 4-bit condition code. It returns a single decision bit. The block is purely combinational and holds no state, so the decision is valid in the same cycle as the inputs.

Each flag group holds four flags. From its most significant bit down to its least significant bit they are: less-than, greater-than, equal and summary-overflow. A condition code names one of these four flags and the value that flag must hold for the branch to be taken. A clear less-than flag therefore means "greater or equal", and a clear greater-than flag means "less or equal". No magnitude comparison takes place here. One extra code means "always taken".

All pins are plain control signals. There is no streaming handshake, because no data moves through the block.

Top module: `branch_cond_eval`

## Requirements
- R1: A `field_sel` of n picks register bits [31-4n : 28-4n], so 0 picks the most significant nibble. Within the picked nibble, the top bit is the less-than flag, the next is greater-than, the next is equal, and the bottom bit is summary-overflow.
- R2: Code 4'b0001 (lt) is taken when the less-than flag is 1. Code 4'b0000 (ge, also used as nl) is taken when that flag is 0.
- R3: Code 4'b0011 (gt) is taken when the greater-than flag is 1. Code 4'b0010 (le, also used as ng) is taken when that flag is 0.
- R4: Code 4'b0101 (eq) is taken when the equal flag is 1. Code 4'b0100 (ne) is taken when it is 0.
- R5: Code 4'b0111 (so) is taken when the summary-overflow flag is 1. Code 4'b0110 (ns) is taken when it is 0.
- R6: Code 4'b1000 is always taken, whatever the register contents and the field select.
- R7: Codes 4'b1001 through 4'b1111 are reserved and are never taken.
- R8: Register bits outside the selected nibble have no effect on `take_branch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cr_value | input | 32 | Complete condition register |
| field_sel | input | 3 | Number of the flag group to test, where 0 is the most significant nibble |
| cond_code | input | 4 | Condition code: bit 0 is the required flag value, bits 3:1 name the flag or the always code |
| take_branch | output | 1 | High when the branch is taken |

## Verification
The bench builds the block with its default parameters: a 32-bit register split into eight 4-bit groups. This small configuration allows a full sweep of every field select, every nibble value and all sixteen codes, which is 2048 vectors. In that sweep, every nibble outside the selected one holds the complement of the tested nibble, so picking the wrong group or the wrong flag changes the result. A second pass fills the other nibbles with pseudo-random values to show that they have no effect.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int FLAG_W = 4;
  localparam int POS_W  = $clog2(FLAG_W);

  // bit 0 = required flag value, bits 2:1 = flag position, bit 3 = special
  typedef enum logic [3:0] {
    CC_GE     = 4'h0,
    CC_LT     = 4'h1,
    CC_LE     = 4'h2,
    CC_GT     = 4'h3,
    CC_NE     = 4'h4,
    CC_EQ     = 4'h5,
    CC_NS     = 4'h6,
    CC_SO     = 4'h7,
    CC_ALWAYS = 4'h8
  } cond_e;

  localparam logic [3:0] CC_NL = 4'h0;  // alias of ge
  localparam logic [3:0] CC_NG = 4'h2;  // alias of le

  // flag position counted from the top bit of a group
  typedef enum logic [POS_W-1:0] {
    FLAG_LT = 2'd0,
    FLAG_GT = 2'd1,
    FLAG_EQ = 2'd2,
    FLAG_SO = 2'd3
  } flag_e;
endpackage

// File: rtl/bce_code_decode.sv
module bce_code_decode
  import bce_pkg::*;
(
  input  logic [3:0] code_i,
  output flag_e      flag_o,
  output logic       want_set_o,
  output logic       force_o,
  output logic       test_en_o
);
  always_comb begin
    flag_o     = flag_e'(code_i[2:1]);
    want_set_o = code_i[0];
    force_o    = (code_i == CC_ALWAYS);
    test_en_o  = ~code_i[3];
  end
endmodule

// File: rtl/bce_field_pick.sv
module bce_field_pick #(
  parameter  int REG_W   = 32,
  parameter  int FIELD_W = 4,
  localparam int NUM_F   = REG_W / FIELD_W,
  localparam int SEL_W   = $clog2(NUM_F)
) (
  input  logic [REG_W-1:0]   reg_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] groups [NUM_F];

  for (genvar g = 0; g < NUM_F; g++) begin : g_split
    assign groups[g] = reg_i[REG_W-1-g*FIELD_W -: FIELD_W];
  end

  assign field_o = groups[sel_i];
endmodule

// File: rtl/bce_bit_test.sv
module bce_bit_test #(
  parameter  int FIELD_W = 4,
  localparam int PW      = $clog2(FIELD_W)
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [PW-1:0]      pos_i,
  input  logic               want_set_i,
  output logic               hit_o
);
  logic [PW-1:0] idx;

  always_comb begin
    idx   = PW'(FIELD_W - 1) - pos_i;
    hit_o = (field_i[idx] == want_set_i);
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter  int REG_W = 32,
  localparam int NUM_F = REG_W / FLAG_W,
  localparam int SEL_W = $clog2(NUM_F),
  localparam int IDX_W = $clog2(REG_W)
) (
  input  logic [REG_W-1:0] cr_value,
  input  logic [SEL_W-1:0] field_sel,
  input  logic [3:0]       cond_code,
  output logic             take_branch
);
  logic [FLAG_W-1:0] field;
  flag_e             flag;
  logic              want_set, force_take, test_en, hit;

  bce_field_pick #(.REG_W(REG_W), .FIELD_W(FLAG_W)) pick_i (
    .reg_i   (cr_value),
    .sel_i   (field_sel),
    .field_o (field)
  );

  bce_code_decode dec_i (
    .code_i     (cond_code),
    .flag_o     (flag),
    .want_set_o (want_set),
    .force_o    (force_take),
    .test_en_o  (test_en)
  );

  bce_bit_test #(.FIELD_W(FLAG_W)) test_i (
    .field_i    (field),
    .pos_i      (flag),
    .want_set_i (want_set),
    .hit_o      (hit)
  );

  assign take_branch = force_take | (test_en & hit);

  // Checks against a flat register index, independent of the group mux
  logic [IDX_W-1:0] lt_at;
  always_comb begin
    lt_at = IDX_W'(REG_W - 1) - IDX_W'(field_sel) * IDX_W'(FLAG_W);
    // R2
    if (cond_code == CC_LT || cond_code == CC_GE) begin
      lt_flag_chk: assert (take_branch == (cr_value[lt_at] == cond_code[0]))
        else $error("lt/ge decision mismatch");
    end
    // R3
    if (cond_code == CC_GT || cond_code == CC_LE) begin
      gt_flag_chk: assert (take_branch == (cr_value[lt_at - 1'b1] == cond_code[0]))
        else $error("gt/le decision mismatch");
    end
    // R4
    if (cond_code == CC_EQ || cond_code == CC_NE) begin
      eq_flag_chk: assert (take_branch == (cr_value[lt_at - 2'd2] == cond_code[0]))
        else $error("eq/ne decision mismatch");
    end
    // R5
    if (cond_code == CC_SO || cond_code == CC_NS) begin
      so_flag_chk: assert (take_branch == (cr_value[lt_at - 2'd3] == cond_code[0]))
        else $error("so/ns decision mismatch");
    end
    // R6
    if (cond_code == CC_ALWAYS) begin
      always_taken_chk: assert (take_branch) else $error("always code not taken");
    end
    // R7
    if (cond_code[3] && cond_code[2:0] != 3'b000) begin
      reserved_never_chk: assert (!take_branch) else $error("reserved code taken");
    end
  end
endmodule

// File: tb/branch_cond_eval_tb_top.sv
`timescale 1ns/1ps
module branch_cond_eval_tb_top;
  logic        clk = 1'b0;
  logic [31:0] cr_value = '0;
  logic [2:0]  field_sel = '0;
  logic [3:0]  cond_code = '0;
  logic        take_branch;
  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #4 clk = ~clk;  // 125 MHz

  branch_cond_eval dut_i (
    .cr_value    (cr_value),
    .field_sel   (field_sel),
    .cond_code   (cond_code),
    .take_branch (take_branch)
  );

  function automatic logic expect_take(logic [31:0] cr, int sel, int code);
    int k;
    if (code == 8) return 1'b1;
    if (code > 8) return 1'b0;
    k = code / 2;                      // 0 lt, 1 gt, 2 eq, 3 so
    return cr[31 - (4 * sel + k)] == logic'(code % 2);
  endfunction

  function automatic string req_of(int code);
    case (code / 2)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return (code == 8) ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cr=%h sel=%0d code=%h take=%b expected=%b",
               req, cr_value, field_sel, cond_code, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] cr, int sel, int code, string tag);
    @(posedge clk);
    cr_value  = cr;
    field_sel = 3'(sel);
    cond_code = 4'(code);
    @(negedge clk);
    check({tag, "/", req_of(code)}, take_branch, expect_take(cr, sel, code));
  endtask

  initial begin
    @(negedge clk);
    // R2: all-zero register with ge must be taken
    check("R2 initial", take_branch, 1'b1);

    // R1 sweep: other groups hold the complement of the tested nibble
    for (int sel = 0; sel < 8; sel++) begin
      for (int nib = 0; nib < 16; nib++) begin
        for (int code = 0; code < 16; code++) begin
          logic [31:0] cr;
          for (int f = 0; f < 8; f++)
            cr[31 - 4 * f -: 4] = (f == sel) ? 4'(nib) : ~4'(nib);
          apply(cr, sel, code, "R1");
        end
      end
    end

    // R8: pseudo-random surroundings, selected nibble held fixed
    for (int i = 0; i < 512; i++) begin
      logic [31:0] cr;
      int sel;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sel = i % 8;
      cr  = lfsr;
      cr[31 - 4 * sel -: 4] = 4'(i / 8);
      apply(cr, sel, (i / 4) % 16, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule